// File: doc/BRIEF.md
# Dual-Channel Power Sequencer

This block decides when each of two regulator channels is allowed to run. A channel is requested when its enable pin and its software enable bit are both high and the master pin (pin 0) is also high. Without the master pin the chip is in shutdown. If the master pin is high but no channel is requested, the chip is in standby. Otherwise it is active. A 2-bit mode selects the policy. Mode 00 gives free-running channels that follow their own requests. Modes 01 and 10 give a cascade in which a leading channel is started first and the trailing channel follows a programmable delay after the leader's power-good. Mode 11 moves both channels as a pair.

Time is counted in half-millisecond ticks from an external strobe. Before any channel starts, a 10 ms hold-off runs. In a cascade, power-down runs in the reverse order. Each running channel reports its soft-start ramp length so that the power stage can shape its reference.

Top module: `pwr_seq_top`

## Requirements
- R1: When `en_pin_i[0]` is low, `chip_state_o` is 00 (shutdown). Any running channel stops on the next clock, and nothing starts.
- R2: When `en_pin_i[0]` is high, `chip_state_o` is 10 (active) if some channel is requested, and 01 (standby) otherwise. Channel c is requested when `en_pin_i[0]`, `en_pin_i[c]` and `sw_en_i[c]` are all high.
- R3: In mode 00 each channel starts and stops on its own request alone. Dropping one channel's request has no effect on the other channel.
- R4: A start first waits 20 ticks of `tick_i` (10 ms) while the request is held, then raises `run_o`. Dropping the request during the wait cancels the start.
- R5: Modes 01 and 10 need both channels requested. The leader starts after the hold-off. In mode 01 CH0 leads; in mode 10 CH1 leads. The trailing channel starts once the leader's `pg_i` has stayed high for the delay.
- R6: `dly_sel_i` maps 00, 01, 10 and 11 to 3, 25, 50 and 100 ticks (1.5, 12.5, 25 and 50 ms).
- R7: If the leader's `pg_i` falls during the delay, the delay restarts from zero and the trailing channel stays off.
- R8: In a cascade, a dropped request stops the trailing channel on the next clock. The leader stops after the same delay in ticks.
- R9: In mode 11 both channels start together after the hold-off. Both stop together on the next clock when either request drops.
- R10: For each running channel, `ss_dur_o[c]` gives the soft-start length in half-ms units: code 00 gives 2, 01 gives 16, 10 gives 1 and 11 gives 8. A stopped channel shows 0.
- R11: While `uvlo_i` is high, no channel starts. Running channels stop on the next clock.
- R12: A fault on a running channel stops only that channel in mode 00, and stops both channels in any other mode. The faulted channel cannot restart until its own request has dropped.
- R13: Mode, delay and soft-start selects are captured only while every channel is idle. Changes made while any channel is busy take effect only at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe every 0.5 ms |
| uvlo_i | input | 1 | Input supply undervoltage lockout |
| en_pin_i | input | 2 | Enable pins; bit 0 is also the master |
| sw_en_i | input | 2 | Software enable bits |
| seq_mode_i | input | 2 | Sequencing mode |
| dly_sel_i | input | 2 | Inter-channel delay select |
| ss_sel_i | input | 2 | Soft-start select |
| pg_i | input | 2 | Power-good per channel |
| fault_i | input | 2 | Fault per channel |
| chip_state_o | output | 2 | 00 shutdown, 01 standby, 10 active |
| run_o | output | 2 | Run request per channel |
| ss_dur_o | output | 2x5 | Soft-start length per channel, half-ms units |

## Verification
The bench attacks the delay counter in three ways: it pulls the leader's power-good low partway through the delay, it shortens the delay select while a cascade is running, and it takes the master pin away during a power-down. A design that keeps counting across a power-good dropout brings the trailing channel up too early. A design that reads the live delay select cuts the reverse power-down short. A design that ignores shutdown keeps the leader running. Fault scenarios check that mode 00 isolates the faulted channel while the cascade modes drop both, and that the fault stays latched until the request is cycled. Either wrong behaviour shows up as a run pattern that differs from the reference model within one clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int SS_W = 5;

  typedef enum logic [1:0] {CHIP_OFF = 2'b00, CHIP_STBY = 2'b01, CHIP_ACT = 2'b10} chip_e;
  typedef enum logic [1:0] {SEQ_FREE = 2'b00, SEQ_0_FIRST = 2'b01, SEQ_1_FIRST = 2'b10, SEQ_JOINT = 2'b11} seq_mode_e;
  typedef enum logic [1:0] {CH_IDLE, CH_HOLD, CH_RUN} ch_st_e;
  typedef enum logic [2:0] {LK_IDLE, LK_HOLD, LK_LEAD, LK_BOTH, LK_DOWN} lk_st_e;

  // soft-start length in half-ms units
  function automatic logic [SS_W-1:0] ss_half_ms(input logic [1:0] code);
    case (code)
      2'b00:   return SS_W'(2);
      2'b01:   return SS_W'(16);
      2'b10:   return SS_W'(1);
      default: return SS_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan import pwr_seq_pkg::*; #(
  parameter int HOLD_TICKS = 20,
  parameter int CNT_W      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic want_i,
  input  logic uvlo_i,
  input  logic flt_i,
  input  logic fault_i,
  output logic run_o,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

  ch_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic abort;

  always_comb begin
    abort = !en_i || uvlo_i || !want_i || (fault_i && st_q == CH_RUN);
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      CH_IDLE: if (!abort && !flt_i) begin
        st_d  = CH_HOLD;
        cnt_d = '0;
      end
      CH_HOLD: begin
        if (abort) st_d = CH_IDLE;
        else if (tick_i) begin
          if (cnt_q == HOLD_LAST) st_d = CH_RUN;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      CH_RUN:  if (abort) st_d = CH_IDLE;
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o  = (st_q == CH_RUN);
  assign busy_o = (st_q != CH_IDLE);
endmodule

// File: rtl/pwr_seq_link.sv
module pwr_seq_link import pwr_seq_pkg::*; #(
  parameter int HOLD_TICKS = 20,
  parameter int CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] dly_last_i,
  input  logic             tick_i,
  input  logic [1:0]       want_i,
  input  logic [1:0]       pg_i,
  input  logic             uvlo_i,
  input  logic             shut_i,
  input  logic             flt_any_i,
  input  logic             fault_hit_i,
  output logic [1:0]       run_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

  lk_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic go, kill, lead_one, lead_pg, joint;
  logic [1:0] lead_mask;

  assign go        = &want_i;
  assign kill      = !en_i || uvlo_i || shut_i || fault_hit_i;
  assign lead_one  = (mode_i == SEQ_1_FIRST);
  assign lead_pg   = lead_one ? pg_i[1] : pg_i[0];
  assign joint     = (mode_i == SEQ_JOINT);
  assign lead_mask = lead_one ? 2'b10 : 2'b01;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      LK_IDLE: if (!kill && go && !flt_any_i) begin
        st_d  = LK_HOLD;
        cnt_d = '0;
      end
      LK_HOLD: begin
        if (kill || !go) st_d = LK_IDLE;
        else if (tick_i) begin
          if (cnt_q == HOLD_LAST) begin
            st_d  = joint ? LK_BOTH : LK_LEAD;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      LK_LEAD: begin
        if (kill || !go) st_d = LK_IDLE;
        else if (!lead_pg) cnt_d = '0;            // leader dropped: restart delay
        else if (tick_i) begin
          if (cnt_q == dly_last_i) st_d = LK_BOTH;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      LK_BOTH: begin
        if (kill) st_d = LK_IDLE;
        else if (!go) begin
          st_d  = joint ? LK_IDLE : LK_DOWN;
          cnt_d = '0;
        end
      end
      LK_DOWN: begin
        if (kill) st_d = LK_IDLE;
        else if (tick_i) begin
          if (cnt_q == dly_last_i) st_d = LK_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (st_q)
      LK_BOTH:          run_o = 2'b11;
      LK_LEAD, LK_DOWN: run_o = lead_mask;
      default:          run_o = 2'b00;
    endcase
  end

  assign busy_o = (st_q != LK_IDLE);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top import pwr_seq_pkg::*; #(
  parameter int HOLD_TICKS = 20,
  parameter int DLY_T0     = 3,
  parameter int DLY_T1     = 25,
  parameter int DLY_T2     = 50,
  parameter int DLY_T3     = 100,
  parameter int CNT_W      = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 uvlo_i,
  input  logic [1:0]           en_pin_i,
  input  logic [1:0]           sw_en_i,
  input  logic [1:0]           seq_mode_i,
  input  logic [1:0]           dly_sel_i,
  input  logic [1:0]           ss_sel_i,
  input  logic [1:0]           pg_i,
  input  logic [1:0]           fault_i,
  output logic [1:0]           chip_state_o,
  output logic [1:0]           run_o,
  output logic [1:0][SS_W-1:0] ss_dur_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] want, chan_run, chan_busy, fault_hit, flt_q;
  logic [1:0]     link_run;
  logic           link_busy, quiet, free;
  logic [1:0]     mode_q, mode_eff, dly_q, dly_eff, ss_q;
  logic [CNT_W-1:0] dly_last;

  assign want[0] = en_pin_i[0] & sw_en_i[0];
  assign want[1] = en_pin_i[0] & en_pin_i[1] & sw_en_i[1];

  always_comb begin
    if (!en_pin_i[0])   chip_state_o = CHIP_OFF;
    else if (|want)     chip_state_o = CHIP_ACT;
    else                chip_state_o = CHIP_STBY;
  end

  // selects are frozen while any sequencer is busy
  assign quiet    = !(|chan_busy) && !link_busy;
  assign mode_eff = quiet ? seq_mode_i : mode_q;
  assign dly_eff  = quiet ? dly_sel_i  : dly_q;
  assign free     = (mode_eff == SEQ_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SEQ_FREE;
      dly_q  <= '0;
      ss_q   <= '0;
    end else if (quiet) begin
      mode_q <= seq_mode_i;
      dly_q  <= dly_sel_i;
      ss_q   <= ss_sel_i;
    end
  end

  always_comb begin
    case (dly_eff)
      2'd0:    dly_last = CNT_W'(DLY_T0 - 1);
      2'd1:    dly_last = CNT_W'(DLY_T1 - 1);
      2'd2:    dly_last = CNT_W'(DLY_T2 - 1);
      default: dly_last = CNT_W'(DLY_T3 - 1);
    endcase
  end

  assign fault_hit = fault_i & run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_q <= '0;
    else         flt_q <= (flt_q | fault_hit) & want;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwr_seq_chan #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (free),
      .tick_i  (tick_i),
      .want_i  (want[g]),
      .uvlo_i  (uvlo_i),
      .flt_i   (flt_q[g]),
      .fault_i (fault_i[g]),
      .run_o   (chan_run[g]),
      .busy_o  (chan_busy[g])
    );
  end

  pwr_seq_link #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (!free),
    .mode_i      (mode_eff),
    .dly_last_i  (dly_last),
    .tick_i      (tick_i),
    .want_i      (want),
    .pg_i        (pg_i),
    .uvlo_i      (uvlo_i),
    .shut_i      (!en_pin_i[0]),
    .flt_any_i   (|flt_q),
    .fault_hit_i (|fault_hit),
    .run_o       (link_run),
    .busy_o      (link_busy)
  );

  assign run_o = free ? chan_run : link_run;

  for (genvar g = 0; g < NCH; g++) begin : g_ss
    assign ss_dur_o[g] = run_o[g] ? ss_half_ms(ss_q) : '0;
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk import pwr_seq_pkg::*; (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 uvlo_i,
  input logic [1:0]           en_pin_i,
  input logic [1:0]           fault_i,
  input logic [1:0]           run_o,
  input logic [1:0][SS_W-1:0] ss_dur_o,
  input logic [1:0]           mode_q
);
  a_r1_shutdown_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_pin_i[0] |=> run_o == 2'b00);

  a_r11_uvlo_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> run_o == 2'b00);

  a_r5_ch0_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SEQ_0_FIRST && run_o[1]) |-> run_o[0]);

  a_r5_ch1_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SEQ_1_FIRST && run_o[0]) |-> run_o[1]);

  a_r9_joint_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == SEQ_JOINT |-> run_o[0] == run_o[1]);

  a_r12_linked_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != SEQ_FREE && (fault_i & run_o) != 2'b00) |=> run_o == 2'b00);

  a_r13_ss0_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o[0] && $past(run_o[0])) |-> $stable(ss_dur_o[0]));

  a_r13_ss1_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o[1] && $past(run_o[1])) |-> $stable(ss_dur_o[1]));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .uvlo_i   (uvlo_i),
  .en_pin_i (en_pin_i),
  .fault_i  (fault_i),
  .run_o    (run_o),
  .ss_dur_o (ss_dur_o),
  .mode_q   (mode_q)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  logic clk = 0, rst_ni = 0, tick_i = 0, uvlo_i = 0;
  logic [1:0] en_pin_i = 0, sw_en_i = 0, seq_mode_i = 0, dly_sel_i = 0, ss_sel_i = 0;
  logic [1:0] pg_i = 0, fault_i = 0;
  logic [1:0] chip_state_o, run_o;
  logic [1:0][4:0] ss_dur_o;

  pwr_seq_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .uvlo_i(uvlo_i),
    .en_pin_i(en_pin_i), .sw_en_i(sw_en_i), .seq_mode_i(seq_mode_i),
    .dly_sel_i(dly_sel_i), .ss_sel_i(ss_sel_i), .pg_i(pg_i), .fault_i(fault_i),
    .chip_state_o(chip_state_o), .run_o(run_o), .ss_dur_o(ss_dur_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // half-ms strobe every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick_i = (tdiv == 0);
  end

  // power-good plant: pg follows run after 6 cycles unless forced low
  bit pg_low [2] = '{0, 0};
  int pgc [2] = '{0, 0};
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (run_o[c] && !pg_low[c]) begin
        if (pgc[c] < 6) pgc[c]++;
      end else pgc[c] = 0;
      pg_i[c] = (pgc[c] >= 6);
    end
  end

  // ---------------- reference model ----------------
  int lk = 0, lkc = 0;          // 0 idle 1 hold 2 lead 3 both 4 down
  int cs [2] = '{0, 0};         // 0 idle 1 hold 2 run
  int cc [2] = '{0, 0};
  bit mf [2] = '{0, 0};
  int mm = 0, md = 0, mss = 0;
  localparam int HOLD = 20;

  function automatic int dly_ticks(int s);
    case (s) 0: return 3; 1: return 25; 2: return 50; default: return 100; endcase
  endfunction
  function automatic int ss_units(int s);
    case (s) 0: return 2; 1: return 16; 2: return 1; default: return 8; endcase
  endfunction
  function automatic bit mrun(int c);
    int ld = (mm == 2) ? 1 : 0;
    if (mm == 0) return cs[c] == 2;
    if (lk == 3) return 1;
    if (lk == 2 || lk == 4) return c == ld;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lk = 0; lkc = 0; cs = '{0, 0}; cc = '{0, 0}; mf = '{0, 0};
      mm = 0; md = 0; mss = 0;
    end else begin
      bit w [2];
      bit hit [2];
      bit oldf [2];
      bit quiet, go, kill;
      int em, dt, ld;
      w[0] = en_pin_i[0] && sw_en_i[0];
      w[1] = en_pin_i[0] && en_pin_i[1] && sw_en_i[1];
      for (int c = 0; c < 2; c++) hit[c] = fault_i[c] && mrun(c);
      quiet = (lk == 0) && (cs[0] == 0) && (cs[1] == 0);
      if (quiet) begin mm = seq_mode_i; md = dly_sel_i; mss = ss_sel_i; end
      em = mm;
      dt = dly_ticks(md);
      ld = (em == 2) ? 1 : 0;
      oldf = mf;
      for (int c = 0; c < 2; c++) mf[c] = (mf[c] || hit[c]) && w[c];
      for (int c = 0; c < 2; c++) begin
        bit ab;
        ab = (em != 0) || uvlo_i || !w[c] || (fault_i[c] && cs[c] == 2);
        if (cs[c] == 0) begin
          if (!ab && !oldf[c]) begin cs[c] = 1; cc[c] = 0; end
        end else if (cs[c] == 1) begin
          if (ab) cs[c] = 0;
          else if (tick_i) begin
            if (cc[c] == HOLD - 1) cs[c] = 2; else cc[c]++;
          end
        end else if (ab) cs[c] = 0;
      end
      go = w[0] && w[1];
      kill = (em == 0) || uvlo_i || !en_pin_i[0] || hit[0] || hit[1];
      case (lk)
        0: if (!kill && go && !oldf[0] && !oldf[1]) begin lk = 1; lkc = 0; end
        1: if (kill || !go) lk = 0;
           else if (tick_i) begin
             if (lkc == HOLD - 1) begin lk = (em == 3) ? 3 : 2; lkc = 0; end
             else lkc++;
           end
        2: if (kill || !go) lk = 0;
           else if (!pg_i[ld]) lkc = 0;
           else if (tick_i) begin
             if (lkc == dt - 1) lk = 3; else lkc++;
           end
        3: if (kill) lk = 0;
           else if (!go) begin lk = (em == 3) ? 0 : 4; lkc = 0; end
        default: if (kill) lk = 0;
           else if (tick_i) begin
             if (lkc == dt - 1) lk = 0; else lkc++;
           end
      endcase
    end
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #3;
    if (rst_ni && !done) begin
      int es;
      es = !en_pin_i[0] ? 0 :
           ((sw_en_i[0] || (en_pin_i[1] && sw_en_i[1])) ? 2 : 1);
      chk(cur_req, "chip_state_o", chip_state_o, es);
      chk(cur_req, "run_o", run_o, {mrun(1), mrun(0)});
      for (int c = 0; c < 2; c++)
        chk(cur_req, $sformatf("ss_dur_o[%0d]", c), ss_dur_o[c],
            mrun(c) ? ss_units(mss) : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_en(logic [1:0] pins, logic [1:0] bits);
    @(negedge clk);
    en_pin_i = pins; sw_en_i = bits;
  endtask
  task automatic quiesce();
    @(negedge clk);
    en_pin_i = 0; sw_en_i = 0; fault_i = 0; uvlo_i = 0;
    pg_low = '{0, 0};
    cyc(6);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk) rst_ni = 1;
    cyc(2);
    cur_req = "R1";
    chk("R1", "reset run_o", run_o, 0);
    chk("R1", "reset chip_state_o", chip_state_o, 0);

    // R1: master pin low blocks channel 1
    set_en(2'b10, 2'b10);
    cyc(120);
    chk("R1", "shutdown run_o", run_o, 0);
    chk("R1", "shutdown state", chip_state_o, 0);

    // R2 standby / active
    cur_req = "R2";
    set_en(2'b11, 2'b00);
    cyc(2);
    chk("R2", "standby state", chip_state_o, 1);
    set_en(2'b11, 2'b10);
    cyc(2);
    chk("R2", "active state", chip_state_o, 2);
    quiesce();

    // R4 hold-off, R3 independent channels
    cur_req = "R4";
    seq_mode_i = 2'b00;
    set_en(2'b11, 2'b01);
    cyc(60);
    chk("R4", "run0 during hold-off", run_o[0], 0);
    cyc(30);
    chk("R4", "run0 after hold-off", run_o[0], 1);
    cur_req = "R3";
    set_en(2'b11, 2'b11);
    cyc(100);
    chk("R3", "both free channels", run_o, 3);
    set_en(2'b11, 2'b01);
    cyc(3);
    chk("R3", "ch1 drop leaves ch0", run_o, 1);
    quiesce();

    // R10 soft-start codes
    cur_req = "R10";
    for (int k = 0; k < 4; k++) begin
      ss_sel_i = 2'(k);
      set_en(2'b01, 2'b01);
      cyc(100);
      chk("R10", "ss_dur ch0", ss_dur_o[0], ss_units(k));
      chk("R10", "ss_dur ch1 off", ss_dur_o[1], 0);
      quiesce();
    end

    // R5/R6 cascade, CH0 first, shortest delay
    cur_req = "R5";
    seq_mode_i = 2'b01; dly_sel_i = 2'b00;
    set_en(2'b11, 2'b11);
    cyc(60);
    chk("R5", "cascade hold-off", run_o, 0);
    cyc(90);
    chk("R5", "cascade both up", run_o, 3);
    quiesce();

    // R7 leader pg dropout restarts delay (R6 code 01 = 25 ticks)
    cur_req = "R7";
    dly_sel_i = 2'b01;
    set_en(2'b11, 2'b11);
    cyc(120);
    pg_low[0] = 1;
    cyc(40);
    pg_low[0] = 0;
    cyc(60);
    chk("R7", "trailing held after dropout", run_o, 1);
    cyc(100);
    chk("R6", "trailing after full delay", run_o, 3);

    // R13 select changes while busy are ignored
    cur_req = "R13";
    seq_mode_i = 2'b11; dly_sel_i = 2'b00; ss_sel_i = 2'b01;
    cyc(5);
    // R8 reverse power-down with captured 25-tick delay
    cur_req = "R8";
    set_en(2'b11, 2'b01);
    cyc(3);
    chk("R8", "trailing off first", run_o, 1);
    cyc(30);
    chk("R13", "old delay still used", run_o, 1);
    cyc(90);
    chk("R8", "leader off after delay", run_o, 0);
    quiesce();

    // R9 joint mode (mode captured now = 11)
    cur_req = "R9";
    set_en(2'b11, 2'b11);
    cyc(60);
    chk("R9", "joint hold-off", run_o, 0);
    cyc(40);
    chk("R9", "joint up", run_o, 3);
    set_en(2'b11, 2'b10);
    cyc(2);
    chk("R9", "joint down", run_o, 0);
    quiesce();

    // R5/R8 CH1 first
    cur_req = "R5";
    seq_mode_i = 2'b10; dly_sel_i = 2'b00;
    set_en(2'b11, 2'b11);
    cyc(150);
    chk("R5", "ch1-first both up", run_o, 3);
    cur_req = "R8";
    set_en(2'b11, 2'b10);
    cyc(3);
    chk("R8", "ch0 off before ch1", run_o, 2);
    // R1 master pin loss aborts power-down
    cur_req = "R1";
    en_pin_i = 2'b10;
    cyc(2);
    chk("R1", "shutdown aborts down", run_o, 0);
    quiesce();

    // R11 undervoltage lockout
    cur_req = "R11";
    seq_mode_i = 2'b00;
    uvlo_i = 1;
    en_pin_i = 2'b01; sw_en_i = 2'b01;
    cyc(120);
    chk("R11", "no start in lockout", run_o, 0);
    uvlo_i = 0;
    cyc(100);
    chk("R11", "start after lockout", run_o, 1);
    uvlo_i = 1;
    cyc(2);
    chk("R11", "lockout stops", run_o, 0);
    quiesce();

    // R12 faults
    cur_req = "R12";
    set_en(2'b11, 2'b11);
    cyc(100);
    fault_i = 2'b10;
    cyc(1);
    fault_i = 2'b00;
    cyc(100);
    chk("R12", "free mode fault isolates ch1", run_o, 1);
    set_en(2'b11, 2'b01);
    set_en(2'b11, 2'b11);
    cyc(100);
    chk("R12", "ch1 restarts after re-enable", run_o, 3);
    quiesce();
    seq_mode_i = 2'b01; dly_sel_i = 2'b00;
    set_en(2'b11, 2'b11);
    cyc(150);
    fault_i = 2'b01;
    cyc(1);
    fault_i = 2'b00;
    cyc(2);
    chk("R12", "cascade fault drops both", run_o, 0);
    cyc(150);
    chk("R12", "cascade stays latched", run_o, 0);
    quiesce();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule